// File: doc/BRIEF.md
# Sample Demultiplexer with Output Modes

This block accepts one converter sample per fast clock cycle, a 10-bit code with an out-of-range flag, and spreads consecutive samples over four output ports, A to D. It uses all four ports (1:4) or only A and B (1:2), so each port runs at a quarter or half of the input rate. The block sends with each port a data-ready strobe that downstream capture logic uses to latch the port.

Ports can update all together on one edge (simultaneous), or one after another, one input period apart (staggered). In simultaneous mode a four-bit flag bus carries the out-of-range bit of the sample on each port. In staggered mode the same bus carries a separate strobe for each port. The strobe is either full-rate, where a word is valid on each rising edge, or half-rate, where both edges mark a word. Samples can be Gray coded before they are spread out. An asynchronous reset fixes which sample lands on port A and when the first word appears. A sleep input freezes the whole pipeline.

The mode inputs (`quad_i`, `stagger_i`, `dr_half_i`, `gray_i`) are expected to change only while `rst_n` is low.

Top module: `sdm_demux`

## Requirements
- R1: With `quad_i` high the samples go to ports A to D (1:4). With it low they go to A and B only (1:2), and port C and D data, their flag bits and their strobes stay 0.
- R2: Counting from the first sample accepted after reset, sample i goes to port (i mod N), where N is 4 or 2 and A=0, B=1, C=2, D=3.
- R3: With `stagger_i` low, the N samples of one word appear on all active ports at the same edge. Edges are counted from 1 at the first edge after reset release. The first word appears after edge N+1 and each later word N edges after the one before.
- R4: With `stagger_i` high, a sample presented before edge i+1 appears on its port after edge i+2. The ports therefore update on successive edges in the order A, B, C, D.
- R5: With `dr_half_i` low, a port's strobe goes low on the edge that updates its word and goes high N/2 edges later. Its rising edge thus falls in the middle of the word.
- R6: With `dr_half_i` high, a port's strobe starts low and toggles N/2 edges after each update of its word, so every strobe edge marks one valid word.
- R7: With `stagger_i` low, `flag_o[k]` is the out-of-range flag of the sample currently on port k (bit 0 = A, bit 3 = D).
- R8: With `stagger_i` high, `flag_o[k]` is port k's own strobe. In both modes `data_rdy_o` is port A's strobe.
- R9: `rst_n` low clears all outputs to 0 at once, without waiting for a clock. After release, a port shows 0 until its first update edge: edge N+1 in simultaneous mode, edge k+2 in staggered mode.
- R10: With `gray_i` high each sample b is output as b ^ (b >> 1). With it low the sample is output unchanged. The out-of-range flag is never coded.
- R11: An edge at which `sleep_i` is high is skipped. All outputs hold, the port phase does not advance, and the sample presented is dropped. Operation resumes as if that edge had not happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_data_i | input | DATA_W | Input sample code |
| smp_ovr_i | input | 1 | Out-of-range flag of the input sample |
| quad_i | input | 1 | 1 = 1:4 ratio, 0 = 1:2 ratio |
| stagger_i | input | 1 | 1 = staggered port updates, 0 = simultaneous |
| dr_half_i | input | 1 | 1 = half-rate strobe, 0 = full-rate strobe |
| gray_i | input | 1 | 1 = Gray output coding, 0 = binary |
| sleep_i | input | 1 | Freeze pipeline and outputs |
| port_a_o | output | DATA_W | Port A data |
| port_b_o | output | DATA_W | Port B data |
| port_c_o | output | DATA_W | Port C data |
| port_d_o | output | DATA_W | Port D data |
| flag_o | output | 4 | Per-port out-of-range bit or per-port strobe |
| data_rdy_o | output | 1 | Data-ready strobe (port A timing) |

## Verification
A sample presented before edge i+1 is registered at that edge. In staggered mode its port changes after edge i+2. In simultaneous mode the whole word lands after the edge that takes its last sample. The strobes move N/2 edges after each word update. The bench numbers the edges that were not skipped by sleep and derives every expected port value, flag bit and strobe level from that count. It checks them at the falling edge after each rising edge, so each result is compared in the first half-cycle where it is due. The asynchronous clear is checked one nanosecond after `rst_n` falls in the middle of a cycle, before any clock edge can act.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    // Number of output ports and width of the port phase counter
    localparam int PORTS = 4;
    localparam int PH_W  = $clog2(PORTS);

    typedef logic [PH_W-1:0] phase_t;

    // Last phase index for each ratio (N-1) and half of a word period (N/2)
    localparam phase_t LAST_QUAD = phase_t'(PORTS - 1);
    localparam phase_t LAST_PAIR = phase_t'(PORTS / 2 - 1);
    localparam phase_t HALF_QUAD = phase_t'(PORTS / 2);
    localparam phase_t HALF_PAIR = phase_t'(PORTS / 4);

endpackage

// File: rtl/sdm_front.sv
module sdm_front
    import sdm_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              quad_i,
    input  logic              gray_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              ovr_i,
    output logic [DATA_W-1:0] s_data_o,
    output logic              s_ovr_o,
    output phase_t            s_ph_o,
    output logic              s_vld_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ovr;
        phase_t            ph;
        logic              vld;
        phase_t            cnt;
    } front_t;

    front_t cur_q, nxt_d;
    phase_t last_ph;

    always_comb begin
        nxt_d   = cur_q;
        last_ph = quad_i ? LAST_QUAD : LAST_PAIR;
        if (!sleep_i) begin
            // coding happens before the sample is assigned to a port
            nxt_d.data = gray_i ? (din_i ^ (din_i >> 1)) : din_i;
            nxt_d.ovr  = ovr_i;
            nxt_d.ph   = cur_q.cnt;
            nxt_d.vld  = 1'b1;
            nxt_d.cnt  = (cur_q.cnt == last_ph) ? '0 : cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign s_data_o = cur_q.data;
    assign s_ovr_o  = cur_q.ovr;
    assign s_ph_o   = cur_q.ph;
    assign s_vld_o  = cur_q.vld;

endmodule

// File: rtl/sdm_lane.sv
module sdm_lane
    import sdm_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int LANE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              quad_i,
    input  logic              stag_i,
    input  logic              half_i,
    input  logic [DATA_W-1:0] s_data_i,
    input  logic              s_ovr_i,
    input  phase_t            s_ph_i,
    input  logic              s_vld_i,
    output logic [DATA_W-1:0] q_data_o,
    output logic              q_ovr_o,
    output logic              q_rdy_o
);

    localparam phase_t K        = phase_t'(LANE);
    localparam logic   LOW_LANE = (LANE < PORTS / 2);

    typedef struct packed {
        logic [DATA_W-1:0] hold_data;
        logic              hold_ovr;
        logic [DATA_W-1:0] out_data;
        logic              out_ovr;
        logic              rdy;
        logic              started;
    } lane_t;

    lane_t  cur_q, nxt_d;
    phase_t last_ph;
    phase_t half_n;
    phase_t upd_ph;
    phase_t mid_ph;
    logic   go;
    logic   mine;

    always_comb begin
        nxt_d   = cur_q;
        last_ph = quad_i ? LAST_QUAD : LAST_PAIR;
        half_n  = quad_i ? HALF_QUAD : HALF_PAIR;
        // simultaneous ports all publish on the last phase of a word
        upd_ph  = stag_i ? K : last_ph;
        mid_ph  = phase_t'(upd_ph + half_n) & last_ph;
        go      = !sleep_i && s_vld_i && (quad_i || LOW_LANE);
        mine    = (s_ph_i == K);

        if (go && mine) begin
            nxt_d.hold_data = s_data_i;
            nxt_d.hold_ovr  = s_ovr_i;
        end

        if (go && s_ph_i == upd_ph) begin
            nxt_d.out_data = mine ? s_data_i : cur_q.hold_data;
            nxt_d.out_ovr  = mine ? s_ovr_i  : cur_q.hold_ovr;
            nxt_d.started  = 1'b1;
            if (!half_i) begin
                nxt_d.rdy = 1'b0;
            end
        end

        if (go && cur_q.started && s_ph_i == mid_ph) begin
            nxt_d.rdy = half_i ? !cur_q.rdy : 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign q_data_o = cur_q.out_data;
    assign q_ovr_o  = cur_q.out_ovr;
    assign q_rdy_o  = cur_q.rdy;

endmodule

// File: rtl/sdm_demux.sv
module sdm_demux
    import sdm_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp_data_i,
    input  logic              smp_ovr_i,
    input  logic              quad_i,
    input  logic              stagger_i,
    input  logic              dr_half_i,
    input  logic              gray_i,
    input  logic              sleep_i,
    output logic [DATA_W-1:0] port_a_o,
    output logic [DATA_W-1:0] port_b_o,
    output logic [DATA_W-1:0] port_c_o,
    output logic [DATA_W-1:0] port_d_o,
    output logic [3:0]        flag_o,
    output logic              data_rdy_o
);

    logic [DATA_W-1:0] s_data;
    logic              s_ovr;
    phase_t            s_ph;
    logic              s_vld;

    logic [DATA_W-1:0] lane_data [PORTS];
    logic [PORTS-1:0]  lane_ovr;
    logic [PORTS-1:0]  lane_rdy;

    sdm_front #(.DATA_W(DATA_W)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_i  (sleep_i),
        .quad_i   (quad_i),
        .gray_i   (gray_i),
        .din_i    (smp_data_i),
        .ovr_i    (smp_ovr_i),
        .s_data_o (s_data),
        .s_ovr_o  (s_ovr),
        .s_ph_o   (s_ph),
        .s_vld_o  (s_vld)
    );

    for (genvar k = 0; k < PORTS; k++) begin : g_lane
        sdm_lane #(.DATA_W(DATA_W), .LANE(k)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .sleep_i  (sleep_i),
            .quad_i   (quad_i),
            .stag_i   (stagger_i),
            .half_i   (dr_half_i),
            .s_data_i (s_data),
            .s_ovr_i  (s_ovr),
            .s_ph_i   (s_ph),
            .s_vld_i  (s_vld),
            .q_data_o (lane_data[k]),
            .q_ovr_o  (lane_ovr[k]),
            .q_rdy_o  (lane_rdy[k])
        );
    end

    assign port_a_o   = lane_data[0];
    assign port_b_o   = lane_data[1];
    assign port_c_o   = lane_data[2];
    assign port_d_o   = lane_data[3];
    // the flag bus is reused as per-port strobes when ports are staggered
    assign flag_o     = stagger_i ? lane_rdy : lane_ovr;
    assign data_rdy_o = lane_rdy[0];

endmodule

// File: rtl/sdm_demux_chk.sv
module sdm_demux_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              quad_i,
    input logic              stagger_i,
    input logic              dr_half_i,
    input logic              sleep_i,
    input logic [DATA_W-1:0] port_a_o,
    input logic [DATA_W-1:0] port_b_o,
    input logic [DATA_W-1:0] port_c_o,
    input logic [DATA_W-1:0] port_d_o,
    input logic [3:0]        flag_o,
    input logic              data_rdy_o
);

    // R1: upper ports stay idle in 1:2 operation
    assert_pair_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !quad_i |-> (port_c_o == '0 && port_d_o == '0 && flag_o[3:2] == 2'b00));

    // R4: staggered ports never change on the same edge
    assert_one_port_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stagger_i |-> $countones({port_a_o != $past(port_a_o), port_b_o != $past(port_b_o),
                                  port_c_o != $past(port_c_o), port_d_o != $past(port_d_o)}) <= 1);

    // R5: a full-rate rising strobe never coincides with a port A change
    assert_full_rise_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dr_half_i && $rose(data_rdy_o)) |-> $stable(port_a_o));

    // R6: a half-rate strobe edge never coincides with a port A change
    assert_half_edge_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_half_i && data_rdy_o != $past(data_rdy_o)) |-> $stable(port_a_o));

    // R11: a sleeping edge leaves every output untouched
    assert_sleep_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> ($stable(port_a_o) && $stable(port_b_o) && $stable(port_c_o)
                     && $stable(port_d_o) && $stable(flag_o) && $stable(data_rdy_o)));

endmodule

bind sdm_demux sdm_demux_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .quad_i     (quad_i),
    .stagger_i  (stagger_i),
    .dr_half_i  (dr_half_i),
    .sleep_i    (sleep_i),
    .port_a_o   (port_a_o),
    .port_b_o   (port_b_o),
    .port_c_o   (port_c_o),
    .port_d_o   (port_d_o),
    .flag_o     (flag_o),
    .data_rdy_o (data_rdy_o)
);

// File: tb/sdm_demux_tb.sv
`timescale 1ns/1ps
module sdm_demux_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] din = '0;
    logic       ovr = 1'b0;
    logic       quad = 1'b0, stag = 1'b0, half = 1'b0, gray = 1'b0, sleep = 1'b0;
    logic [9:0] pa, pb, pc, pd;
    logic [3:0] flag;
    logic       drdy;

    int vectors = 0;
    int miscomp = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    sdm_demux #(.DATA_W(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_data_i(din), .smp_ovr_i(ovr),
        .quad_i(quad), .stagger_i(stag), .dr_half_i(half), .gray_i(gray),
        .sleep_i(sleep), .port_a_o(pa), .port_b_o(pb), .port_c_o(pc),
        .port_d_o(pd), .flag_o(flag), .data_rdy_o(drdy)
    );

    // Mode table: [7] 1:4, [6] staggered, [5] half-rate, [4] Gray, [3:0] first sleep cycle (0 = none)
    localparam int NCFG = 7;
    localparam logic [7:0] CFG [NCFG] = '{
        8'b1000_0000,
        8'b0000_0000,
        8'b1100_0000,
        8'b1110_0000,
        8'b1011_0000,
        8'b0100_1101,
        8'b1001_1011
    };
    localparam int NCYC  = 36;
    localparam int SLLEN = 5;

    function automatic logic [9:0] smp_val(int i);
        return 10'((i * 37 + 5) % 1024);
    endfunction

    function automatic logic smp_flag(int i);
        return (i % 3) == 0;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscomp++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [9:0] port_of(int k);
        case (k)
            0: return pa;
            1: return pb;
            2: return pc;
            default: return pd;
        endcase
    endfunction

    // e = number of non-sleeping edges since reset release
    task automatic check_all(input int e, input bit sl);
        int n;
        logic rdy_a;
        n = quad ? 4 : 2;
        rdy_a = 1'b0;
        for (int k = 0; k < 4; k++) begin
            logic [9:0] ed;
            logic       eo, er;
            int p0, j, r, s;
            string td, tf;
            ed = '0; eo = 1'b0; er = 1'b0;
            p0 = stag ? k + 2 : n + 1;
            if (k < n && e >= p0) begin
                j  = (e - p0) / n;
                r  = (e - p0) % n;
                s  = j * n + k;
                ed = gray ? (smp_val(s) ^ (smp_val(s) >> 1)) : smp_val(s);
                eo = smp_flag(s);
                if (half) er = (((r >= n / 2) ? j + 1 : j) % 2) == 1;
                else      er = (r >= n / 2);
            end
            if (k == 0) rdy_a = er;
            if (sl)                    td = "R11";
            else if (k >= n)           td = "R1";
            else if (e < p0)           td = "R9";
            else if (gray)             td = "R10";
            else if (stag)             td = "R4";
            else if (quad)             td = "R2";
            else                       td = "R3";
            if (sl)                    tf = "R11";
            else if (k >= n)           tf = "R1";
            else if (stag)             tf = "R8";
            else                       tf = "R7";
            chk(td, $sformatf("port%0d data e=%0d", k, e), 32'(port_of(k)), 32'(ed));
            chk(tf, $sformatf("flag%0d e=%0d", k, e), 32'(flag[k]), 32'(stag ? er : eo));
        end
        chk(sl ? "R11" : (half ? "R6" : "R5"), $sformatf("data_rdy e=%0d", e), 32'(drdy), 32'(rdy_a));
    endtask

    task automatic check_zero(input string why);
        chk("R9", {why, " port A"}, 32'(pa), 0);
        chk("R9", {why, " port B"}, 32'(pb), 0);
        chk("R9", {why, " port C"}, 32'(pc), 0);
        chk("R9", {why, " port D"}, 32'(pd), 0);
        chk("R9", {why, " flags"}, 32'(flag), 0);
        chk("R9", {why, " data_rdy"}, 32'(drdy), 0);
    endtask

    task automatic run_cfg(input logic [7:0] c, input int ncyc);
        int e;
        @(negedge clk);
        rst_n = 1'b0;
        sleep = 1'b0;
        {quad, stag, half, gray} = c[7:4];
        repeat (2) @(negedge clk);
        check_zero("reset state");
        rst_n = 1'b1;
        e = 0;
        for (int cyc = 0; cyc < ncyc; cyc++) begin
            bit sl;
            sl = (c[3:0] != 0) && (cyc >= c[3:0]) && (cyc < c[3:0] + SLLEN);
            sleep = sl;
            din   = sl ? (10'h3ff ^ 10'(cyc * 91)) : smp_val(e);
            ovr   = sl ? 1'b1 : smp_flag(e);
            @(posedge clk);
            if (!sl) e++;
            @(negedge clk);
            check_all(e, sl);
        end
        sleep = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NCFG; i++) begin
            run_cfg(CFG[i], NCYC);
        end
        // Directed: asynchronous clear in the middle of a running 1:4 staggered stream
        run_cfg(8'b1100_0000, 12);
        @(posedge clk);
        #2 rst_n = 1'b0;
        #1 check_zero("async clear");
        // Directed: restart after the clear lands on port A again in 1:2 simultaneous mode
        run_cfg(8'b0000_0000, 8);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscomp++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

endmodule